// File: doc/BRIEF.md
# Boundary-Scan Test Port with Management Instructions

This block is the serial test port of a system-management device. A four-wire boundary-scan port drives a sixteen-state controller and a five-bit instruction register. The instruction that is loaded chooses which data register sits between the serial input and the serial output.

Three data registers are built in:
- a one-bit pass-through stage;
- a fixed 32-bit identity word;
- a 32-bit user word, assembled at capture time from the live bus slave address and firmware version inputs.

Three instructions hand the data path to an external memory-access shift chain. For those, the block raises a select line for each one and passes out the capture, shift and update state levels. The same chain's serial bit returns on `mem_tdo`.

Other instructions give a one-clock restart strobe or fault-store strobe when the controller enters the idle state. Four further instructions set or clear two sticky page-access flags.

There is no streaming data interface, so no back-pressure applies. All pins are plain levels, sampled on the rising test clock. Serial output changes on the falling test clock.

Top module: `jtag_mgmt_tap`

## Requirements
- R1: An asserted `trst_n` (active low), or five consecutive rising `tck` edges with `tms` high, puts the controller in Test-Logic-Reset. In that state the instruction becomes 00h (identity), and both page flags and both strobes are low.
- R2: The controller follows the standard sixteen-state boundary-scan transition graph on `tms` at each rising `tck`.
- R3: In Capture-IR the instruction shift register loads binary 00001. Shift-IR then shifts it out least significant bit first, with `tdi` entering at the top.
- R4: With instruction 00h, Capture-DR loads 0x00001197. That word is a 4-bit version of 0, a 16-bit device number of 1, the 11-bit maker code 00011001011 and a 1 in bit 0. Shift-DR shifts it out least significant bit first.
- R5: With instruction 03h, Capture-DR loads a user word: bits 31:15 are zero, bits 14:8 are `slave_addr` and bits 7:0 are `fw_version`, both as sampled at that capture. It shifts out like the identity word.
- R6: Instruction 1Fh, and any code with no other meaning (07h–0Ch included), places a one-bit register between `tdi` and `tdo`. That register captures 0, so each shifted bit appears one cycle later.
- R7: `tdo` and `tdo_oe` change only on the falling edge of `tck`. `tdo_oe` is high only for the cycles the controller spends in Shift-IR or Shift-DR.
- R8: On Update-IR, code 09h sets `xpage_on` and 0Ah clears it; 0Bh sets `nvpage_on` and 0Ch clears it. No other code and no other state changes them, except Test-Logic-Reset, which clears both.
- R9: With code 07h loaded, `restart_pulse` is high for exactly the first `tck` cycle of each entry into Run-Test/Idle. Code 08h does the same on `fault_store_pulse`. The strobe does not repeat while the controller stays idle.
- R10: Codes 04h, 05h and 06h raise `mem_sel_addr`, `mem_sel_rd` and `mem_sel_wr` respectively, at most one at a time. Under these codes Shift-DR drives `tdo` from `mem_tdo`, and `dr_capture`, `dr_shift` and `dr_update` are high in the matching controller states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low (ignored when HAS_TRST=0) |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| slave_addr | input | 7 | Bus slave address, placed in user word bits 14:8 |
| fw_version | input | 8 | Firmware version, placed in user word bits 7:0 |
| mem_tdo | input | 1 | Serial return from the external memory-access chain |
| tdo | output | 1 | Serial test data out |
| tdo_oe | output | 1 | Output enable for `tdo` |
| mem_sel_addr | output | 1 | Address-load instruction active |
| mem_sel_rd | output | 1 | Memory-read instruction active |
| mem_sel_wr | output | 1 | Memory-write instruction active |
| dr_capture | output | 1 | Controller is in Capture-DR |
| dr_shift | output | 1 | Controller is in Shift-DR |
| dr_update | output | 1 | Controller is in Update-DR |
| restart_pulse | output | 1 | One-cycle restart strobe |
| fault_store_pulse | output | 1 | One-cycle fault-store strobe |
| xpage_on | output | 1 | Sticky extended-page flag |
| nvpage_on | output | 1 | Sticky non-volatile page flag |

## Verification
Two events can share a cycle. The edge out of Update-IR writes the new instruction. The very next cycle, the first in Run-Test/Idle, must already raise the strobe that this new instruction selects.

The bench loads 07h and 08h and steps straight from Update-IR into idle. It judges the strobe on that first idle cycle and its absence on the following one.

A second overlap is a page-flag instruction followed by a reset through `tms`. The bench checks that the reset clears the flag the update had just set.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

  localparam int IR_W = 5;

  typedef enum logic [3:0] {
    TLR, RTI,
    SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {SEL_BYP, SEL_ID, SEL_USER, SEL_MEM} dr_sel_e;

  localparam logic [IR_W-1:0] OP_IDCODE      = 5'h00;
  localparam logic [IR_W-1:0] OP_USER        = 5'h03;
  localparam logic [IR_W-1:0] OP_MEM_ADDR    = 5'h04;
  localparam logic [IR_W-1:0] OP_MEM_RD      = 5'h05;
  localparam logic [IR_W-1:0] OP_MEM_WR      = 5'h06;
  localparam logic [IR_W-1:0] OP_RESTART     = 5'h07;
  localparam logic [IR_W-1:0] OP_FAULT_STORE = 5'h08;
  localparam logic [IR_W-1:0] OP_XPAGE_ON    = 5'h09;
  localparam logic [IR_W-1:0] OP_XPAGE_OFF   = 5'h0A;
  localparam logic [IR_W-1:0] OP_NVPAGE_ON   = 5'h0B;
  localparam logic [IR_W-1:0] OP_NVPAGE_OFF  = 5'h0C;
  localparam logic [IR_W-1:0] OP_BYPASS      = 5'h1F;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
    tap_state_e n;
    unique case (s)
      TLR:    n = tms ? TLR    : RTI;
      RTI:    n = tms ? SEL_DR : RTI;
      SEL_DR: n = tms ? SEL_IR : CAP_DR;
      CAP_DR: n = tms ? EX1_DR : SH_DR;
      SH_DR:  n = tms ? EX1_DR : SH_DR;
      EX1_DR: n = tms ? UPD_DR : PAU_DR;
      PAU_DR: n = tms ? EX2_DR : PAU_DR;
      EX2_DR: n = tms ? UPD_DR : SH_DR;
      UPD_DR: n = tms ? SEL_DR : RTI;
      SEL_IR: n = tms ? TLR    : CAP_IR;
      CAP_IR: n = tms ? EX1_IR : SH_IR;
      SH_IR:  n = tms ? EX1_IR : SH_IR;
      EX1_IR: n = tms ? UPD_IR : PAU_IR;
      PAU_IR: n = tms ? EX2_IR : PAU_IR;
      EX2_IR: n = tms ? UPD_IR : SH_IR;
      UPD_IR: n = tms ? SEL_DR : RTI;
      default: n = TLR;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import jtag_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= TLR;
    else        state <= tap_next(state, tms);
  end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import jtag_tap_pkg::*;
#(
  parameter logic [IR_W-1:0] CAP_PAT = 5'b00001
) (
  input  logic            tck,
  input  logic            rst_n,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_lsb,
  output dr_sel_e         dr_sel,
  output logic            sel_addr,
  output logic            sel_rd,
  output logic            sel_wr,
  output logic            xpage_on,
  output logic            nvpage_on,
  output logic            restart_pulse,
  output logic            fault_store_pulse
);

  logic [IR_W-1:0] ir_sr;
  logic            was_idle;
  logic            idle_entry;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      ir_sr     <= '0;
      ir_q      <= OP_IDCODE;
      xpage_on  <= 1'b0;
      nvpage_on <= 1'b0;
      was_idle  <= 1'b0;
    end else begin
      was_idle <= (state == RTI);
      case (state)
        TLR: begin
          ir_q      <= OP_IDCODE;
          xpage_on  <= 1'b0;
          nvpage_on <= 1'b0;
        end
        CAP_IR: ir_sr <= CAP_PAT;
        SH_IR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        UPD_IR: begin
          ir_q <= ir_sr;
          case (ir_sr)
            OP_XPAGE_ON:   xpage_on  <= 1'b1;
            OP_XPAGE_OFF:  xpage_on  <= 1'b0;
            OP_NVPAGE_ON:  nvpage_on <= 1'b1;
            OP_NVPAGE_OFF: nvpage_on <= 1'b0;
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  assign ir_lsb     = ir_sr[0];
  assign idle_entry = (state == RTI) && !was_idle;
  assign restart_pulse     = idle_entry && (ir_q == OP_RESTART);
  assign fault_store_pulse = idle_entry && (ir_q == OP_FAULT_STORE);
  assign sel_addr = (ir_q == OP_MEM_ADDR);
  assign sel_rd   = (ir_q == OP_MEM_RD);
  assign sel_wr   = (ir_q == OP_MEM_WR);

  always_comb begin
    case (ir_q)
      OP_IDCODE:                       dr_sel = SEL_ID;
      OP_USER:                         dr_sel = SEL_USER;
      OP_MEM_ADDR, OP_MEM_RD, OP_MEM_WR: dr_sel = SEL_MEM;
      default:                         dr_sel = SEL_BYP;
    endcase
  end

endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import jtag_tap_pkg::*;
#(
  parameter int              DR_W    = 32,
  parameter int              ADDR_W  = 7,
  parameter int              FW_W    = 8,
  parameter logic [DR_W-1:0] ID_WORD = 32'h0000_1197
) (
  input  logic              tck,
  input  logic              rst_n,
  input  tap_state_e        state,
  input  dr_sel_e           dr_sel,
  input  logic              tdi,
  input  logic [ADDR_W-1:0] slave_addr,
  input  logic [FW_W-1:0]   fw_version,
  output logic              dr_lsb
);

  localparam int UC_PAD = DR_W - ADDR_W - FW_W;

  logic [DR_W-1:0] sr_q;
  logic [DR_W-1:0] user_word;
  logic            byp_q;

  assign user_word = {{UC_PAD{1'b0}}, slave_addr, fw_version};

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      byp_q <= 1'b0;
    end else begin
      case (state)
        CAP_DR: begin
          byp_q <= 1'b0;
          sr_q  <= (dr_sel == SEL_USER) ? user_word : ID_WORD;
        end
        SH_DR: begin
          byp_q <= tdi;
          sr_q  <= {tdi, sr_q[DR_W-1:1]};
        end
        default: ;
      endcase
    end
  end

  assign dr_lsb = (dr_sel == SEL_ID || dr_sel == SEL_USER) ? sr_q[0] : byp_q;

endmodule

// File: rtl/jtag_mgmt_tap.sv
module jtag_mgmt_tap
  import jtag_tap_pkg::*;
#(
  parameter bit          HAS_TRST   = 1'b1,
  parameter int          ADDR_W     = 7,
  parameter int          FW_W       = 8,
  parameter logic [3:0]  ID_VERSION = 4'h0,
  parameter logic [15:0] ID_PART    = 16'h0001,
  parameter logic [10:0] ID_MAKER   = 11'b000_1100_1011
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tms,
  input  logic              tdi,
  input  logic [ADDR_W-1:0] slave_addr,
  input  logic [FW_W-1:0]   fw_version,
  input  logic              mem_tdo,
  output logic              tdo,
  output logic              tdo_oe,
  output logic              mem_sel_addr,
  output logic              mem_sel_rd,
  output logic              mem_sel_wr,
  output logic              dr_capture,
  output logic              dr_shift,
  output logic              dr_update,
  output logic              restart_pulse,
  output logic              fault_store_pulse,
  output logic              xpage_on,
  output logic              nvpage_on
);

  localparam int              DR_W    = 32;
  localparam logic [DR_W-1:0] ID_WORD = {ID_VERSION, ID_PART, ID_MAKER, 1'b1};

  logic            rst_n;
  tap_state_e      tap_state;
  logic [IR_W-1:0] cur_ir;
  logic            ir_lsb;
  logic            dr_lsb;
  dr_sel_e         dr_sel;

  generate
    if (HAS_TRST) begin : g_trst
      assign rst_n = trst_n;
    end else begin : g_no_trst
      logic unused_trst;
      assign unused_trst = trst_n;
      assign rst_n = 1'b1;
    end
  endgenerate

  tap_fsm u_fsm (
    .tck   (tck),
    .rst_n (rst_n),
    .tms   (tms),
    .state (tap_state)
  );

  tap_ir u_ir (
    .tck               (tck),
    .rst_n             (rst_n),
    .state             (tap_state),
    .tdi               (tdi),
    .ir_q              (cur_ir),
    .ir_lsb            (ir_lsb),
    .dr_sel            (dr_sel),
    .sel_addr          (mem_sel_addr),
    .sel_rd            (mem_sel_rd),
    .sel_wr            (mem_sel_wr),
    .xpage_on          (xpage_on),
    .nvpage_on         (nvpage_on),
    .restart_pulse     (restart_pulse),
    .fault_store_pulse (fault_store_pulse)
  );

  tap_dr #(
    .DR_W    (DR_W),
    .ADDR_W  (ADDR_W),
    .FW_W    (FW_W),
    .ID_WORD (ID_WORD)
  ) u_dr (
    .tck        (tck),
    .rst_n      (rst_n),
    .state      (tap_state),
    .dr_sel     (dr_sel),
    .tdi        (tdi),
    .slave_addr (slave_addr),
    .fw_version (fw_version),
    .dr_lsb     (dr_lsb)
  );

  assign dr_capture = (tap_state == CAP_DR);
  assign dr_shift   = (tap_state == SH_DR);
  assign dr_update  = (tap_state == UPD_DR);

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (tap_state == SH_IR) || (tap_state == SH_DR);
      if (tap_state == SH_IR)      tdo <= ir_lsb;
      else if (tap_state == SH_DR) tdo <= (dr_sel == SEL_MEM) ? mem_tdo : dr_lsb;
    end
  end

endmodule

// File: rtl/jtag_mgmt_tap_chk.sv
module jtag_mgmt_tap_chk
  import jtag_tap_pkg::*;
(
  input logic            tck,
  input logic            trst_n,
  input tap_state_e      state,
  input logic [IR_W-1:0] ir_q,
  input logic            tdo_oe,
  input logic            xpage_on,
  input logic            nvpage_on,
  input logic            restart_pulse,
  input logic            fault_store_pulse,
  input logic            mem_sel_addr,
  input logic            mem_sel_rd,
  input logic            mem_sel_wr
);

  // R1
  tlr_loads_id_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TLR) |=> (ir_q == OP_IDCODE));

  // R7
  oe_in_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (state == SH_IR || state == SH_DR));

  // R8
  xpage_change_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !$stable(xpage_on) |-> ($past(state) == UPD_IR || $past(state) == TLR));

  // R8
  nvpage_change_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !$stable(nvpage_on) |-> ($past(state) == UPD_IR || $past(state) == TLR));

  // R9
  restart_single_chk: assert property (@(posedge tck) disable iff (!trst_n)
    restart_pulse |=> !restart_pulse);

  // R9
  store_single_chk: assert property (@(posedge tck) disable iff (!trst_n)
    fault_store_pulse |=> !fault_store_pulse);

  // R10
  mem_sel_onehot_chk: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({mem_sel_addr, mem_sel_rd, mem_sel_wr}));

endmodule

bind jtag_mgmt_tap jtag_mgmt_tap_chk u_chk (
  .tck               (tck),
  .trst_n            (trst_n),
  .state             (tap_state),
  .ir_q              (cur_ir),
  .tdo_oe            (tdo_oe),
  .xpage_on          (xpage_on),
  .nvpage_on         (nvpage_on),
  .restart_pulse     (restart_pulse),
  .fault_store_pulse (fault_store_pulse),
  .mem_sel_addr      (mem_sel_addr),
  .mem_sel_rd        (mem_sel_rd),
  .mem_sel_wr        (mem_sel_wr)
);

// File: tb/sim_jtag_mgmt_tap.sv
`timescale 1ns/1ps
module sim_jtag_mgmt_tap;

  logic       tck = 1'b0;
  logic       trst_n = 1'b0;
  logic       tms = 1'b1;
  logic       tdi = 1'b0;
  logic [6:0] slave_addr = 7'h00;
  logic [7:0] fw_version = 8'h00;
  logic       mem_tdo = 1'b0;
  logic       tdo, tdo_oe, mem_sel_addr, mem_sel_rd, mem_sel_wr;
  logic       dr_capture, dr_shift, dr_update;
  logic       restart_pulse, fault_store_pulse, xpage_on, nvpage_on;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic s_tdo, s_oe, s_rst, s_sav, s_dsh;
  bit   edge_bad;

  always #5 tck = ~tck;

  jtag_mgmt_tap u0 (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .slave_addr(slave_addr), .fw_version(fw_version), .mem_tdo(mem_tdo),
    .tdo(tdo), .tdo_oe(tdo_oe),
    .mem_sel_addr(mem_sel_addr), .mem_sel_rd(mem_sel_rd), .mem_sel_wr(mem_sel_wr),
    .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update),
    .restart_pulse(restart_pulse), .fault_store_pulse(fault_store_pulse),
    .xpage_on(xpage_on), .nvpage_on(nvpage_on)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic t_ms, input logic t_di);
    @(negedge tck); #1;
    tms = t_ms; tdi = t_di;
    #1;
    s_tdo = tdo; s_oe = tdo_oe; s_rst = restart_pulse; s_sav = fault_store_pulse; s_dsh = dr_shift;
    @(posedge tck); #1;
    if (tdo !== s_tdo || tdo_oe !== s_oe) edge_bad = 1;
  endtask

  task automatic tms_reset();
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  task automatic load_ir(input logic [4:0] op, output logic [4:0] cap, output bit oe_all);
    oe_all = 1;
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 5; i++) begin
      step(i == 4, op[i]);
      cap[i] = s_tdo;
      oe_all &= s_oe;
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic shift_dr(input int n, input logic [31:0] din, output logic [31:0] dout,
                          output bit oe_all, output bit sh_all);
    dout = '0; oe_all = 1; sh_all = 1;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i]);
      dout[i] = s_tdo;
      oe_all &= s_oe;
      sh_all &= s_dsh;
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic t_reset();
    logic [31:0] d; bit oe, sh;
    trst_n = 0; #23; trst_n = 1;
    step(0, 0);
    check("R1 reset outputs", {26'd0, tdo_oe, xpage_on, nvpage_on, restart_pulse, fault_store_pulse, mem_sel_rd}, 32'd0);
    shift_dr(32, 32'h0, d, oe, sh);
    check("R1 id after reset", d, 32'h0000_1197);
    step(0, 0);
    check("R7 oe low in idle", {31'd0, s_oe}, 32'd0);
  endtask

  task automatic t_ir_capture();
    logic [4:0] c; bit oe;
    load_ir(5'h1F, c, oe);
    check("R3 capture pattern", {27'd0, c}, 32'h1);
    check("R7 oe in shift-ir", {31'd0, oe}, 32'd1);
    load_ir(5'h03, c, oe);
    check("R3 capture after other op", {27'd0, c}, 32'h1);
  endtask

  task automatic t_idcode();
    logic [4:0] c; bit oe, sh; logic [31:0] d;
    logic [4:0] cap;
    load_ir(5'h00, c, oe);
    edge_bad = 0;
    shift_dr(32, 32'hFFFF_FFFF, d, oe, sh);
    check("R4 id word", d, 32'h0000_1197);
    check("R7 oe in shift-dr", {31'd0, oe}, 32'd1);
    check("R7 tdo stable at rising edge", {31'd0, edge_bad}, 32'd0);
    // R2: pause-DR / exit2 path: capture, shift 4, pause, resume 4
    step(1, 0); step(0, 0); step(0, 0);
    d = '0;
    for (int i = 0; i < 4; i++) begin step(i == 3, 1'b0); d[i] = s_tdo; end
    step(0, 0); step(0, 0); step(1, 0); step(0, 0);
    for (int i = 4; i < 8; i++) begin step(i == 7, 1'b0); d[i] = s_tdo; end
    step(1, 0); step(0, 0);
    check("R2 pause-dr resume", d & 32'hFF, 32'h97);
    cap = '0;
    check("R2 idle afterwards", {31'd0, s_dsh}, 32'd0);
  endtask

  task automatic t_user();
    logic [4:0] c; bit oe, sh; logic [31:0] d;
    load_ir(5'h03, c, oe);
    slave_addr = 7'h5A; fw_version = 8'hC3;
    shift_dr(32, 32'h0, d, oe, sh);
    check("R5 user word", d, 32'h0000_5AC3);
    slave_addr = 7'h7F; fw_version = 8'h01;
    shift_dr(32, 32'h0, d, oe, sh);
    check("R5 user word live", d, 32'h0000_7F01);
  endtask

  task automatic t_bypass();
    logic [4:0] c; bit oe, sh; logic [31:0] d;
    load_ir(5'h1F, c, oe);
    shift_dr(8, 32'hA5, d, oe, sh);
    check("R6 bypass 1Fh", d & 32'hFF, 32'h4A);
    load_ir(5'h15, c, oe);
    shift_dr(8, 32'h3C, d, oe, sh);
    check("R6 bypass undefined 15h", d & 32'hFF, 32'h78);
    load_ir(5'h09, c, oe);
    shift_dr(4, 32'hF, d, oe, sh);
    check("R6 bypass under 09h", d & 32'hF, 32'hE);
  endtask

  task automatic t_flags();
    logic [4:0] c; bit oe;
    tms_reset();
    load_ir(5'h09, c, oe);
    check("R8 xpage set", {30'd0, xpage_on, nvpage_on}, 32'h2);
    load_ir(5'h0B, c, oe);
    check("R8 nvpage set", {30'd0, xpage_on, nvpage_on}, 32'h3);
    load_ir(5'h0A, c, oe);
    check("R8 xpage clear", {30'd0, xpage_on, nvpage_on}, 32'h1);
    load_ir(5'h1F, c, oe);
    check("R8 other op no change", {30'd0, xpage_on, nvpage_on}, 32'h1);
    load_ir(5'h0C, c, oe);
    check("R8 nvpage clear", {30'd0, xpage_on, nvpage_on}, 32'h0);
    load_ir(5'h09, c, oe);
    tms_reset();
    check("R1 tms reset clears flag", {30'd0, xpage_on, nvpage_on}, 32'h0);
    load_ir(5'h0B, c, oe);
    trst_n = 0; #7; trst_n = 1;
    check("R1 trst clears flag", {30'd0, xpage_on, nvpage_on}, 32'h0);
    step(0, 0);
  endtask

  task automatic t_pulses();
    logic [4:0] c; bit oe;
    load_ir(5'h07, c, oe);
    step(0, 0);
    check("R9 restart first idle", {30'd0, s_rst, s_sav}, 32'h2);
    step(0, 0);
    check("R9 restart not repeated", {30'd0, s_rst, s_sav}, 32'h0);
    load_ir(5'h08, c, oe);
    step(0, 0);
    check("R9 store first idle", {30'd0, s_rst, s_sav}, 32'h1);
    step(0, 0);
    check("R9 store not repeated", {30'd0, s_rst, s_sav}, 32'h0);
    load_ir(5'h00, c, oe);
    step(0, 0);
    check("R9 no strobe for id", {30'd0, s_rst, s_sav}, 32'h0);
  endtask

  task automatic t_mem();
    logic [4:0] c; bit oe, sh; logic [31:0] d;
    load_ir(5'h04, c, oe);
    check("R10 addr select", {29'd0, mem_sel_addr, mem_sel_rd, mem_sel_wr}, 32'h4);
    load_ir(5'h06, c, oe);
    check("R10 write select", {29'd0, mem_sel_addr, mem_sel_rd, mem_sel_wr}, 32'h1);
    load_ir(5'h05, c, oe);
    check("R10 read select", {29'd0, mem_sel_addr, mem_sel_rd, mem_sel_wr}, 32'h2);
    mem_tdo = 1;
    shift_dr(4, 32'h0, d, oe, sh);
    check("R10 tdo from mem_tdo high", d & 32'hF, 32'hF);
    check("R10 dr_shift level", {31'd0, sh}, 32'd1);
    mem_tdo = 0;
    shift_dr(4, 32'hF, d, oe, sh);
    check("R10 tdo from mem_tdo low", d & 32'hF, 32'h0);
    load_ir(5'h1F, c, oe);
    check("R10 selects drop", {29'd0, mem_sel_addr, mem_sel_rd, mem_sel_wr}, 32'h0);
  endtask

  initial begin
    t_reset();
    t_ir_capture();
    t_idcode();
    t_user();
    t_bypass();
    t_flags();
    t_pulses();
    t_mem();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule